// File: doc/BRIEF.md
# Adaptive Slope Delta Codec Loop

This block is the fully digital loop of a half-duplex delta modulator whose step size adapts to the signal slope. One bit moves per clock. In encode mode the loop bit is the result of an external comparator that sets the audio input against the estimate. In decode mode the loop bit is the received serial NRZ bit. In both modes the loop keeps a 10-bit offset-binary estimate, centred at 512, that drives an external DAC. When encoding, that estimate serves as the side tone. When decoding, it is the recovered audio.

A three-bit history of loop bits detects runs of identical bits, which indicate slope overload. While a run lasts, a syllabic step register grows. Otherwise it decays geometrically. The estimate leaks toward mid-scale and moves up or down by the current step. A loop-control state machine has three states:
- ST_QUIET: force-zero is held or reset has just occurred.
- ST_TRACK: normal computation.
- ST_CLAMP: the estimate is pinned at three-quarter scale and the step register is frozen.

Its transitions are:
- any → ST_QUIET while force-zero is low.
- ST_QUIET/ST_TRACK → ST_CLAMP when the candidate estimate reaches the limit.
- ST_QUIET/ST_TRACK → ST_TRACK otherwise.
- ST_CLAMP → ST_TRACK when the candidate falls back inside the limit.
- ST_CLAMP → ST_CLAMP otherwise.

An active-low level flag marks large excursions. Two quieting controls can replace the transmitted stream with an alternating pattern.

Top module: `cvsd_codec`

## Requirements
- R1: A synchronous active-low reset at a rising edge sets the estimate to 512, the step to 1 LSB, and the bit history to 0,1,0, and enters ST_QUIET. After reset `level_n` is 1. `tx_bit` is 0 after any falling edge at which reset is low.
- R2: At each rising edge the loop bit is sampled. It is `cmp_above` when `mode_dec` is 0 (encode) and `rx_bit` when `mode_dec` is 1 (decode). A loop bit of 1 means the estimate should rise.
- R3: The step register keeps 6 fractional bits. If the newest three loop bits, including the current one, are all equal, the step register gains 2 LSB. Otherwise it loses one 64th of its value, truncated. The result is bounded to 1..48 LSB. The integer part of the step register, sampled before the update, is the step applied to the estimate.
- R4: In ST_TRACK and ST_QUIET (with force-zero released), the candidate estimate is est − floor((est − 512)/16) ± step. The sign is + for a loop bit of 1. The estimate takes the candidate when its distance from 512 is below 384.
- R5: If the candidate is 384 or more away from 512, the estimate is pinned at 896 or 128 (same polarity) and the state becomes ST_CLAMP. In ST_CLAMP the step register holds. The estimate stays pinned until a candidate, computed from the pinned value, falls inside the limit; the estimate then takes that candidate and returns to ST_TRACK.
- R6: `level_n` is 0 exactly when the estimate is 256 or more away from 512 in either direction, and 1 otherwise.
- R7: With both quieting inputs high, `tx_bit` changes only on falling clock edges. At each falling edge it takes the loop bit sampled at the preceding rising edge.
- R8: While `force_zero_n` is 0 at a rising edge, that edge loads estimate 512, step 1, and history 0,1,0. While it is 0 at a falling edge, `tx_bit` inverts.
- R9: While `plain_quiet_n` is 0 at a falling edge, `tx_bit` inverts. The loop meanwhile keeps updating the estimate from real loop bits exactly as in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one data bit per period |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dec | input | 1 | 0 = encode, 1 = decode |
| cmp_above | input | 1 | Comparator result: 1 when audio is above the estimate |
| rx_bit | input | 1 | Received NRZ bit (decode) |
| force_zero_n | input | 1 | Active-low force-zero |
| plain_quiet_n | input | 1 | Active-low transmit-only quieting |
| tx_bit | output | 1 | Transmitted NRZ bit, updated on falling edges |
| estimate | output | 10 | Offset-binary signal estimate for the DAC |
| level_n | output | 1 | Active-low half-scale excursion flag |

## Verification
The bench drives square-wave audio and long runs of ones and zeros in decode. Together these push the estimate into the three-quarter clamp and force the step to its ceiling. A design that keeps adapting the step while pinned, or that never unclamps, then drifts away from the model's estimate within a few cycles. A leak that rounds negative deviations the wrong way shows up as a one-LSB bias below mid-scale. Force-zero and plain-quiet are each held across many falling edges. This exposes a swapped edge, a tx pattern that fails to alternate, and a plain-quiet that wrongly freezes the estimate. Moderate triangles make the level flag toggle, which catches an off-by-one at the 256 threshold.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_TRACK = 2'd1,
        ST_CLAMP = 2'd2
    } loop_state_t;
endpackage

// File: rtl/cvsd_run_detect.sv
module cvsd_run_detect #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_idle,
    input  logic bit_in,
    output logic run
);
    localparam logic [HIST_LEN-1:0] IDLE_PAT = HIST_LEN'({(HIST_LEN+1)/2{2'b10}});

    logic [HIST_LEN-1:0] hist_q;
    logic [HIST_LEN-1:0] hist_d;

    // Window of the newest bits, current bit included.
    always_comb begin
        hist_d = {hist_q[HIST_LEN-2:0], bit_in};
        run    = (&hist_d) | ~(|hist_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load_idle) hist_q <= IDLE_PAT;
        else                     hist_q <= hist_d;
    end
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
    parameter int STEP_MIN   = 1,
    parameter int STEP_MAX   = 48,
    parameter int STEP_INC   = 2,
    parameter int FRAC       = 6,
    parameter int SYL_SHIFT  = 6,
    parameter int STEP_W     = $clog2(STEP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hold,
    input  logic              load_min,
    output logic [STEP_W-1:0] step
);
    localparam int SF_W = STEP_W + FRAC + 1;
    localparam logic [SF_W-1:0] MINF = SF_W'(STEP_MIN) << FRAC;
    localparam logic [SF_W-1:0] MAXF = SF_W'(STEP_MAX) << FRAC;
    localparam logic [SF_W-1:0] INCF = SF_W'(STEP_INC) << FRAC;

    logic [SF_W-1:0] acc_q;
    logic [SF_W-1:0] raw;
    logic [SF_W-1:0] acc_d;

    always_comb begin
        raw = run ? (acc_q + INCF) : (acc_q - (acc_q >> SYL_SHIFT));
        if (raw < MINF)      acc_d = MINF;
        else if (raw > MAXF) acc_d = MAXF;
        else                 acc_d = raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load_min) acc_q <= MINF;
        else if (!hold)         acc_q <= acc_d;
    end

    assign step = acc_q[FRAC +: STEP_W];

    a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >= MINF) && (acc_q <= MAXF));
    a_r3_run_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hold && !load_min && (acc_q < MAXF)) |=> (acc_q > $past(acc_q)));
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
    parameter int EST_W      = 10,
    parameter int STEP_W     = 6,
    parameter int LEAK_SHIFT = 4
) (
    input  logic [EST_W-1:0]  est,
    input  logic [STEP_W-1:0] step,
    input  logic              up,
    output logic [EST_W-1:0]  cand,
    output logic              over,
    output logic [EST_W-1:0]  pin
);
    localparam int ES = EST_W + 2;
    localparam logic signed [ES-1:0] MID_S = ES'(1 << (EST_W - 1));
    localparam logic signed [ES-1:0] LIM_S = ES'(3 << (EST_W - 3));

    logic signed [ES-1:0] est_s, dev, leak, step_s, cand_s, cdev;

    always_comb begin
        est_s  = $signed({2'b00, est});
        dev    = est_s - MID_S;
        leak   = dev >>> LEAK_SHIFT;
        step_s = $signed({{(ES-STEP_W){1'b0}}, step});
        cand_s = est_s - leak + (up ? step_s : -step_s);
        cdev   = cand_s - MID_S;
        over   = (cdev >= LIM_S) || (cdev <= -LIM_S);
        cand   = cand_s[EST_W-1:0];
        pin    = cdev[ES-1] ? EST_W'(MID_S - LIM_S) : EST_W'(MID_S + LIM_S);
    end
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
    parameter int EST_W      = 10,
    parameter int STEP_MIN   = 1,
    parameter int STEP_MAX   = 48,
    parameter int STEP_INC   = 2,
    parameter int FRAC       = 6,
    parameter int SYL_SHIFT  = 6,
    parameter int LEAK_SHIFT = 4,
    parameter int HIST_LEN   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_dec,
    input  logic             cmp_above,
    input  logic             rx_bit,
    input  logic             force_zero_n,
    input  logic             plain_quiet_n,
    output logic             tx_bit,
    output logic [EST_W-1:0] estimate,
    output logic             level_n
);
    import cvsd_pkg::*;

    localparam int STEP_W = $clog2(STEP_MAX + 1);
    localparam int ES     = EST_W + 2;
    localparam logic [EST_W-1:0]      MID   = EST_W'(1 << (EST_W - 1));
    localparam logic signed [ES-1:0]  MID_S = ES'(1 << (EST_W - 1));
    localparam logic signed [ES-1:0]  HALF_S = ES'(1 << (EST_W - 2));
    localparam logic signed [ES-1:0]  LIM_S = ES'(3 << (EST_W - 3));

    loop_state_t       st_q, st_d;
    logic [EST_W-1:0]  est_q, est_d;
    logic              bit_q, tx_q;
    logic              loop_bit, run, step_hold, load_idle;
    logic [STEP_W-1:0] step_w;
    logic [EST_W-1:0]  cand, pin;
    logic              over;
    logic signed [ES-1:0] dev_out;

    assign loop_bit  = mode_dec ? rx_bit : cmp_above;
    assign load_idle = !force_zero_n;

    cvsd_run_detect #(.HIST_LEN(HIST_LEN)) u_runs (
        .clk(clk), .rst_n(rst_n), .load_idle(load_idle),
        .bit_in(loop_bit), .run(run)
    );

    cvsd_syllabic #(
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INC(STEP_INC),
        .FRAC(FRAC), .SYL_SHIFT(SYL_SHIFT), .STEP_W(STEP_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(step_hold),
        .load_min(load_idle), .step(step_w)
    );

    cvsd_integrator #(.EST_W(EST_W), .STEP_W(STEP_W), .LEAK_SHIFT(LEAK_SHIFT)) u_integ (
        .est(est_q), .step(step_w), .up(loop_bit),
        .cand(cand), .over(over), .pin(pin)
    );

    // Next-state and datapath selection.
    always_comb begin
        st_d      = st_q;
        est_d     = est_q;
        step_hold = 1'b0;
        if (!force_zero_n) begin
            st_d  = ST_QUIET;
            est_d = MID;
        end else begin
            unique case (st_q)
                ST_QUIET, ST_TRACK: begin
                    if (over) begin
                        st_d  = ST_CLAMP;
                        est_d = pin;
                    end else begin
                        st_d  = ST_TRACK;
                        est_d = cand;
                    end
                end
                ST_CLAMP: begin
                    step_hold = 1'b1;
                    if (!over) begin
                        st_d  = ST_TRACK;
                        est_d = cand;
                    end
                end
                default: begin
                    st_d  = ST_QUIET;
                    est_d = MID;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_QUIET;
            est_q <= MID;
            bit_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            est_q <= est_d;
            bit_q <= loop_bit;
        end
    end

    // Transmit register on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)                               tx_q <= 1'b0;
        else if (!force_zero_n || !plain_quiet_n) tx_q <= ~tx_q;
        else                                      tx_q <= bit_q;
    end

    // Outputs.
    always_comb begin
        dev_out  = $signed({2'b00, est_q}) - MID_S;
        level_n  = !((dev_out >= HALF_S) || (dev_out <= -HALF_S));
        estimate = est_q;
        tx_bit   = tx_q;
    end

    a_r5_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out <= LIM_S) && (dev_out >= -LIM_S));
    a_r5_clamp_freezes_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLAMP && force_zero_n) |=> $stable(step_w));
    a_r8_force_centres: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_zero_n) |=> (est_q == MID && st_q == ST_QUIET));
    a_r8_force_min_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_zero_n) |=> (step_w == STEP_W'(STEP_MIN)));
endmodule

// File: tb/cvsd_codec_bench.sv
`timescale 1ns/1ps
module cvsd_codec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_dec = 1'b0;
    logic cmp_above = 1'b0;
    logic rx_bit = 1'b0;
    logic force_zero_n = 1'b1;
    logic plain_quiet_n = 1'b1;
    logic tx_bit;
    logic [9:0] estimate;
    logic level_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference state
    int m_est = 512;
    int m_step = 64;       // step with 6 fractional bits
    int m_hist[$];
    bit m_clamp = 0;
    bit m_quiet = 1;
    bit m_bit = 0;
    bit m_tx = 0;
    bit m_run = 0;
    int stim = 512;

    always #2.5 clk = ~clk;

    cvsd_codec u_cvsd_codec (
        .clk(clk), .rst_n(rst_n), .mode_dec(mode_dec), .cmp_above(cmp_above),
        .rx_bit(rx_bit), .force_zero_n(force_zero_n), .plain_quiet_n(plain_quiet_n),
        .tx_bit(tx_bit), .estimate(estimate), .level_n(level_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_rise();
        int b, stp, d, cand, cd;
        bit over;
        if (!rst_n) begin
            m_est = 512; m_step = 64; m_clamp = 0; m_quiet = 1; m_bit = 0;
            m_hist = '{0, 1, 0};
            return;
        end
        b = mode_dec ? int'(rx_bit) : int'(cmp_above);
        m_bit = b[0];
        if (!force_zero_n) begin
            m_est = 512; m_step = 64; m_clamp = 0; m_quiet = 1;
            m_hist = '{0, 1, 0};
            return;
        end
        m_quiet = 0;
        m_hist.push_back(b);
        void'(m_hist.pop_front());
        m_run = (m_hist[0] == m_hist[1]) && (m_hist[1] == m_hist[2]);
        stp  = m_step / 64;
        d    = m_est - 512;
        cand = m_est - (d >>> 4) + (b != 0 ? stp : -stp);
        cd   = cand - 512;
        over = (cd >= 384) || (cd <= -384);
        if (!m_clamp) begin
            if (m_run) m_step = m_step + 128;
            else       m_step = m_step - (m_step / 64);
            if (m_step < 64)   m_step = 64;
            if (m_step > 3072) m_step = 3072;
            if (over) begin
                m_est = (cd > 0) ? 896 : 128;
                m_clamp = 1;
            end else m_est = cand;
        end else if (!over) begin
            m_est = cand;
            m_clamp = 0;
        end
    endtask

    task automatic model_fall();
        if (!rst_n) m_tx = 0;
        else if (!force_zero_n || !plain_quiet_n) m_tx = ~m_tx;
        else m_tx = m_bit;
    endtask

    // One clock: model and compare after each edge, then drive the comparator.
    task automatic cycle();
        string rq, tq;
        int dv;
        @(posedge clk);
        model_rise();
        #1;
        if (!rst_n) rq = "R1";
        else if (!force_zero_n) rq = "R8";
        else if (m_clamp) rq = "R5";
        else if (!plain_quiet_n) rq = "R9";
        else if (mode_dec) rq = "R2";
        else if (m_run) rq = "R3";
        else rq = "R4";
        check(rq, int'(estimate), m_est);
        dv = m_est - 512;
        check("R6", int'(level_n), (dv >= 256 || dv <= -256) ? 0 : 1);
        @(negedge clk);
        model_fall();
        #1;
        if (!rst_n) tq = "R1";
        else if (!force_zero_n) tq = "R8";
        else if (!plain_quiet_n) tq = "R9";
        else tq = "R7";
        check(tq, int'(tx_bit), int'(m_tx));
        cmp_above = (stim > m_est);
    endtask

    initial begin
        int lfsr;
        m_hist = '{0, 1, 0};
        // R1: reset state
        repeat (4) cycle();
        check("R1", int'(estimate), 512);
        check("R1", int'(level_n), 1);
        check("R1", int'(tx_bit), 0);
        rst_n = 1'b1;

        // R4/R6: encode a moderate triangle
        for (int i = 0; i < 800; i++) begin
            int ph = i % 200;
            stim = (ph < 100) ? 200 + ph * 6 : 800 - (ph - 100) * 6;
            cycle();
        end
        // R5/R3: square wave at full range
        for (int i = 0; i < 600; i++) begin
            stim = ((i / 150) % 2 == 0) ? 1023 : 0;
            cycle();
        end
        // R9: plain quiet during encode, loop keeps running
        plain_quiet_n = 1'b0;
        for (int i = 0; i < 300; i++) begin
            stim = ((i / 60) % 2 == 0) ? 900 : 150;
            cycle();
        end
        plain_quiet_n = 1'b1;
        // R2: decode with pseudo-random stream, then long runs
        mode_dec = 1'b1;
        lfsr = 16'hACE1;
        for (int i = 0; i < 500; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0);
            rx_bit = lfsr[0];
            cycle();
        end
        for (int i = 0; i < 400; i++) begin
            rx_bit = ((i / 100) % 2 == 0);
            cycle();
        end
        // R8: force zero while clamped, then release into encode
        force_zero_n = 1'b0;
        repeat (60) cycle();
        check("R8", int'(estimate), 512);
        force_zero_n = 1'b1;
        mode_dec = 1'b0;
        for (int i = 0; i < 400; i++) begin
            stim = 512 + ((i % 80) < 40 ? 330 : -330);
            cycle();
        end
        // R1: reset in mid-run
        rst_n = 1'b0;
        repeat (3) cycle();
        check("R1", int'(estimate), 512);
        check("R1", int'(tx_bit), 0);
        rst_n = 1'b1;
        repeat (20) cycle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule